// File: doc/BRIEF.md
# Registered Bidirectional Byte Transceiver

This block joins two byte-wide ports, A and B, through a pair of one-way paths. Each path has its own storage register, capture strobe, output enable and source select. A path either forwards the opposite port's live value or replays the byte it last captured. The two storage registers load on rising edges of their strobes whatever the enables and selects are doing, so a byte can be snapshotted while the port is busy with something else.

Each port is split into an observed input pair (an external-drive flag plus its value), a driven value and an output enable. There are no internal tri-states: a pad wrapper outside the block resolves the real wires. Inside, each port's seen value is resolved by a fixed priority. External drive comes first, then the block's own enabled output, then the last seen value. That priority lets the block model the case where both paths are enabled in live mode and the two buses hold each other's last value. The strobes are sampled on one system clock and their rising edges are detected there.

Top module: `xcvr_top`

## Requirements
- R1: The A-to-B register captures the resolved value of port A, and the B-to-A register captures the resolved value of port B; both are 8 bits wide (parameter default).
- R2: A register loads on the first clock edge at which its strobe is sampled high after being sampled low, taking the port value present in that same cycle. It does not load again while the strobe stays high, and the load does not depend on the enables or selects.
- R3: `en_ab` is active high and enables port B's driver (`b_oe`); `en_ba_n` is active low and enables port A's driver (`a_oe`). With `en_ab`=0 and `en_ba_n`=1 both outputs are disabled.
- R4: The select is 0 for live and 1 for stored. Select 0 drives the opposite port's resolved value; select 1 drives that path's storage register.
- R5: If a port is driven from the opposite path's register and the port's own capture strobe rises, that same byte lands in the second register, so both registers hold it.
- R6: A port's resolved value is its external value when `*_ext_drv` is 1. Otherwise it is the block's own output when that output is enabled, and otherwise the value last resolved.
- R7: With both paths enabled, both selects 0 and an external driver on one port, the driven value appears on the other port. After the driver is removed, both ports keep that value on later cycles.
- R8: With `en_ab`=1, `en_ba_n`=0 and both selects 1, port A shows the B-to-A register and port B shows the A-to-B register at the same time.
- R9: Toggling a select changes the driven value in that cycle directly from the old source to the new one, with no third value at any sample point within the cycle.
- R10: A synchronous reset (`rst` high) clears both registers to zero and the strobe history, and it holds both output enables low. A strobe that is already high when reset is released is captured on the first edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_ext_drv | input | 1 | Another device is driving port A |
| a_ext_val | input | 8 | Value driven onto port A from outside |
| b_ext_drv | input | 1 | Another device is driving port B |
| b_ext_val | input | 8 | Value driven onto port B from outside |
| cap_ab | input | 1 | Capture strobe, A-to-B register |
| cap_ba | input | 1 | Capture strobe, B-to-A register |
| en_ab | input | 1 | Port B driver enable, active high |
| en_ba_n | input | 1 | Port A driver enable, active low |
| sel_ab | input | 1 | Source for port B: 0 live A, 1 stored |
| sel_ba | input | 1 | Source for port A: 0 live B, 1 stored |
| a_out | output | 8 | Value the block drives onto port A |
| a_oe | output | 1 | Port A driver enable |
| b_out | output | 8 | Value the block drives onto port B |
| b_oe | output | 1 | Port B driver enable |

## Verification
The hardest state to reach is the latch formed by the two live paths. It exists only when no external driver is present and each port is driven from the other, so it cannot be set up directly. The stimulus first enables both live paths while one port is externally driven, lets one clock edge record the value on both sides, and then drops the driver. The copy-into-both-registers case is reached the same way: a byte is loaded into one register, replayed onto its port, and then captured by the other path's strobe with no external drive on that port.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] data;
        logic         strb;
    } store_t;

    store_t st_d, st_q;
    logic   rise;

    always_comb begin
        st_d      = st_q;
        rise      = strobe && !st_q.strb;
        st_d.strb = strobe;
        if (rise) begin
            st_d.data = din;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.data;

    AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (rst)
        rise |=> (q == $past(din))); // R2

    AST_NO_EDGE_KEEP: assert property (@(posedge clk) disable iff (rst)
        !rise |=> (q == $past(q))); // R2

endmodule

// File: rtl/xcvr_port_view.sv
module xcvr_port_view #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ext_drv,
    input  logic [W-1:0] ext_val,
    input  logic         oe,
    input  logic         stored_src,
    input  logic [W-1:0] stored_val,
    input  logic [W-1:0] own_out,
    output logic [W-1:0] base,
    output logic [W-1:0] view
);

    typedef struct packed {
        logic [W-1:0] hold;
    } view_t;

    view_t vw_d, vw_q;

    always_comb begin
        if (ext_drv) begin
            base = ext_val;
        end else if (oe && stored_src) begin
            base = stored_val;
        end else begin
            base = vw_q.hold;
        end

        if (ext_drv) begin
            view = ext_val;
        end else if (oe) begin
            view = own_out;
        end else begin
            view = vw_q.hold;
        end

        vw_d.hold = view;
        if (rst) begin
            vw_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        vw_q <= vw_d;
    end

    AST_FLOAT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ext_drv && !oe && !$past(rst)) |-> (view == $past(view))); // R6

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         strobe,
    input  logic [W-1:0] cap_src,
    input  logic [W-1:0] live_src,
    input  logic         sel,
    output logic [W-1:0] q,
    output logic [W-1:0] drive
);

    src_sel_e src;

    xcvr_store #(.W(W)) store_i (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .din    (cap_src),
        .q      (q)
    );

    always_comb begin
        src = src_sel_e'(sel);
        unique case (src)
            SRC_STORED: drive = q;
            default:    drive = live_src;
        endcase
    end

endmodule

// File: rtl/xcvr_top.sv
module xcvr_top #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_ext_drv,
    input  logic [DATA_W-1:0] a_ext_val,
    input  logic              b_ext_drv,
    input  logic [DATA_W-1:0] b_ext_val,
    input  logic              cap_ab,
    input  logic              cap_ba,
    input  logic              en_ab,
    input  logic              en_ba_n,
    input  logic              sel_ab,
    input  logic              sel_ba,
    output logic [DATA_W-1:0] a_out,
    output logic              a_oe,
    output logic [DATA_W-1:0] b_out,
    output logic              b_oe
);

    logic [DATA_W-1:0] ab_q, ba_q;
    logic [DATA_W-1:0] a_base, b_base, a_view, b_view;

    assign a_oe = !rst && !en_ba_n;
    assign b_oe = !rst && en_ab;

    xcvr_port_view #(.W(DATA_W)) view_a_i (
        .clk        (clk),
        .rst        (rst),
        .ext_drv    (a_ext_drv),
        .ext_val    (a_ext_val),
        .oe         (a_oe),
        .stored_src (sel_ba),
        .stored_val (ba_q),
        .own_out    (a_out),
        .base       (a_base),
        .view       (a_view)
    );

    xcvr_port_view #(.W(DATA_W)) view_b_i (
        .clk        (clk),
        .rst        (rst),
        .ext_drv    (b_ext_drv),
        .ext_val    (b_ext_val),
        .oe         (b_oe),
        .stored_src (sel_ab),
        .stored_val (ab_q),
        .own_out    (b_out),
        .base       (b_base),
        .view       (b_view)
    );

    xcvr_dir #(.W(DATA_W)) dir_ab_i (
        .clk      (clk),
        .rst      (rst),
        .strobe   (cap_ab),
        .cap_src  (a_view),
        .live_src (a_base),
        .sel      (sel_ab),
        .q        (ab_q),
        .drive    (b_out)
    );

    xcvr_dir #(.W(DATA_W)) dir_ba_i (
        .clk      (clk),
        .rst      (rst),
        .strobe   (cap_ba),
        .cap_src  (b_view),
        .live_src (b_base),
        .sel      (sel_ba),
        .q        (ba_q),
        .drive    (a_out)
    );

    AST_STORED_ON_B: assert property (@(posedge clk) disable iff (rst)
        (b_oe && sel_ab && !b_ext_drv) |-> (b_view == ab_q)); // R4

    AST_STORED_ON_A: assert property (@(posedge clk) disable iff (rst)
        (a_oe && sel_ba && !a_ext_drv) |-> (a_view == ba_q)); // R4

    AST_COPY_BOTH: assert property (@(posedge clk) disable iff (rst)
        (a_oe && sel_ba && !a_ext_drv && cap_ab && !$past(cap_ab) && !cap_ba && !$past(rst))
        |=> (ab_q == ba_q)); // R5

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> (!a_oe && !b_oe)); // R10

endmodule

// File: tb/xcvr_top_tb_top.sv
module xcvr_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       a_ext_drv, b_ext_drv;
    logic [7:0] a_ext_val, b_ext_val;
    logic       cap_ab, cap_ba, en_ab, en_ba_n, sel_ab, sel_ba;
    logic [7:0] a_out, b_out;
    logic       a_oe, b_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    xcvr_top #(.DATA_W(8)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .a_ext_drv (a_ext_drv),
        .a_ext_val (a_ext_val),
        .b_ext_drv (b_ext_drv),
        .b_ext_val (b_ext_val),
        .cap_ab    (cap_ab),
        .cap_ba    (cap_ba),
        .en_ab     (en_ab),
        .en_ba_n   (en_ba_n),
        .sel_ab    (sel_ab),
        .sel_ba    (sel_ba),
        .a_out     (a_out),
        .a_oe      (a_oe),
        .b_out     (b_out),
        .b_oe      (b_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic idle();
        a_ext_drv = 1'b0; a_ext_val = 8'h00;
        b_ext_drv = 1'b0; b_ext_val = 8'h00;
        cap_ab = 1'b0; cap_ba = 1'b0;
        en_ab = 1'b0; en_ba_n = 1'b1;
        sel_ab = 1'b0; sel_ba = 1'b0;
    endtask

    task automatic pulse_ab();
        cap_ab = 1'b1; tick(); cap_ab = 1'b0; tick();
    endtask

    task automatic pulse_ba();
        cap_ba = 1'b1; tick(); cap_ba = 1'b0; tick();
    endtask

    // load A-to-B register from an external value on A, ports isolated
    task automatic load_ab(input logic [7:0] v);
        idle();
        a_ext_drv = 1'b1; a_ext_val = v;
        pulse_ab();
        a_ext_drv = 1'b0;
    endtask

    task automatic load_ba(input logic [7:0] v);
        idle();
        b_ext_drv = 1'b1; b_ext_val = v;
        pulse_ba();
        b_ext_drv = 1'b0;
    endtask

    task automatic t_reset();
        idle();
        rst = 1'b1;
        en_ab = 1'b1; en_ba_n = 1'b0;
        tick(); tick(); settle();
        chk("R10 a_oe in reset", {7'b0, a_oe}, 8'h00);
        chk("R10 b_oe in reset", {7'b0, b_oe}, 8'h00);
        rst = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
        settle();
        chk("R10 ab cleared", b_out, 8'h00);
        chk("R10 ba cleared", a_out, 8'h00);
        chk("R3 b_oe after reset", {7'b0, b_oe}, 8'h01);
        // strobe already high when reset releases
        idle();
        a_ext_drv = 1'b1; a_ext_val = 8'h5C;
        cap_ab = 1'b1; rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        cap_ab = 1'b0; a_ext_drv = 1'b0;
        en_ab = 1'b1; sel_ab = 1'b1; settle();
        chk("R10 strobe high at release captured", b_out, 8'h5C);
    endtask

    task automatic t_isolate();
        idle(); settle();
        chk("R3 isolate a_oe", {7'b0, a_oe}, 8'h00);
        chk("R3 isolate b_oe", {7'b0, b_oe}, 8'h00);
        en_ab = 1'b1; settle();
        chk("R3 en_ab high b_oe", {7'b0, b_oe}, 8'h01);
        chk("R3 en_ab high a_oe", {7'b0, a_oe}, 8'h00);
        en_ab = 1'b0; en_ba_n = 1'b0; settle();
        chk("R3 en_ba_n low a_oe", {7'b0, a_oe}, 8'h01);
        chk("R3 en_ba_n low b_oe", {7'b0, b_oe}, 8'h00);
    endtask

    task automatic t_live();
        idle();
        en_ab = 1'b1;
        a_ext_drv = 1'b1; a_ext_val = 8'h3C; settle();
        chk("R4 live A to B", b_out, 8'h3C);
        a_ext_val = 8'hA5; settle();
        chk("R4 live A to B follows", b_out, 8'hA5);
        idle();
        en_ba_n = 1'b0;
        b_ext_drv = 1'b1; b_ext_val = 8'h96; settle();
        chk("R4 live B to A", a_out, 8'h96);
    endtask

    task automatic t_capture();
        load_ab(8'h11);
        load_ba(8'h22);
        // strobe rise and data change in the same cycle, then held strobe
        idle();
        a_ext_drv = 1'b1; a_ext_val = 8'h44; cap_ab = 1'b1;
        tick();
        a_ext_val = 8'h55;
        tick(); tick();
        cap_ab = 1'b0; a_ext_drv = 1'b0;
        en_ab = 1'b1; sel_ab = 1'b1; settle();
        chk("R2 same-cycle data captured, no recapture while high", b_out, 8'h44);
        en_ab = 1'b0; en_ba_n = 1'b0; sel_ba = 1'b1; settle();
        chk("R1 B-to-A register holds port B byte", a_out, 8'h22);
        en_ab = 1'b1; settle();
        chk("R8 stored on A", a_out, 8'h22);
        chk("R8 stored on B", b_out, 8'h44);
    endtask

    task automatic t_copy();
        load_ba(8'hC3);
        idle();
        en_ba_n = 1'b0; sel_ba = 1'b1; settle();
        chk("R4 stored BA on A", a_out, 8'hC3);
        pulse_ab();
        idle();
        en_ab = 1'b1; sel_ab = 1'b1; settle();
        chk("R5 A-to-B copies replayed byte", b_out, 8'hC3);
        load_ab(8'h6E);
        idle();
        en_ab = 1'b1; sel_ab = 1'b1;
        pulse_ba();
        idle();
        en_ba_n = 1'b0; sel_ba = 1'b1; settle();
        chk("R5 B-to-A copies replayed byte", a_out, 8'h6E);
    endtask

    task automatic t_priority();
        // port A driven by block (6E) and externally (77): external wins
        idle();
        en_ba_n = 1'b0; sel_ba = 1'b1;
        a_ext_drv = 1'b1; a_ext_val = 8'h77;
        pulse_ab();
        idle();
        en_ab = 1'b1; sel_ab = 1'b1; settle();
        chk("R6 external beats own output", b_out, 8'h77);
        // floating and disabled port keeps last value
        idle();
        a_ext_drv = 1'b1; a_ext_val = 8'h33;
        tick();
        a_ext_drv = 1'b0; a_ext_val = 8'hEE;
        tick(); tick();
        pulse_ab();
        en_ab = 1'b1; sel_ab = 1'b1; settle();
        chk("R6 floating port holds last value", b_out, 8'h33);
    endtask

    task automatic t_loop();
        idle();
        en_ab = 1'b1; en_ba_n = 1'b0;
        a_ext_drv = 1'b1; a_ext_val = 8'h5A; settle();
        chk("R7 driven A reaches B", b_out, 8'h5A);
        tick();
        a_ext_drv = 1'b0; a_ext_val = 8'h00;
        tick(); tick(); tick(); settle();
        chk("R7 loop holds A", a_out, 8'h5A);
        chk("R7 loop holds B", b_out, 8'h5A);
        b_ext_drv = 1'b1; b_ext_val = 8'h81; settle();
        chk("R7 driven B reaches A", a_out, 8'h81);
        tick();
        b_ext_drv = 1'b0;
        tick(); tick(); settle();
        chk("R7 loop holds new A", a_out, 8'h81);
        chk("R7 loop holds new B", b_out, 8'h81);
    endtask

    task automatic t_select();
        load_ab(8'hF0);
        idle();
        en_ab = 1'b1;
        a_ext_drv = 1'b1; a_ext_val = 8'h0F; settle();
        chk("R9 live before switch", b_out, 8'h0F);
        sel_ab = 1'b1;
        #1 chk("R9 stored right after switch", b_out, 8'hF0);
        #4 chk("R9 stored mid cycle", b_out, 8'hF0);
        #4 chk("R9 stored late cycle", b_out, 8'hF0);
        tick();
        sel_ab = 1'b0;
        #1 chk("R9 live after switch back", b_out, 8'h0F);
        #6 chk("R9 live mid cycle", b_out, 8'h0F);
    endtask

    initial begin
        idle();
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_isolate();
        t_live();
        t_capture();
        t_copy();
        t_priority();
        t_loop();
        t_select();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule